// File: doc/BRIEF.md
# Timer Output Toggle Controller

This block owns one timer output bit and decides, every clock, whether that bit keeps its value, flips, or is forced to a level. It watches a 16-bit up-counter against two programmable reference values. The first cycle the counter equals a reference counts as a match. Each match raises a one-cycle interrupt pulse and can flip the output. Two capture-latch strobes from a neighbouring capture unit can flip the output as well. Each of the four flip sources has its own enable.

Software drives the bit through a 2-bit command written with a strobe. The commands are invert, force high and force low. A valid command wins over any hardware flips arriving in the same cycle. When several enabled hardware sources fire together, each one flips the bit, so only the parity of the firing sources matters. The output bit is meant to feed a timer output pin through port logic that lies outside this block.

The core is a two-state machine. Its states are `ST_LOW` and `ST_HIGH`, and its transitions are hold, flip, force-high and force-low. A flip takes the machine to the other state. Force-high goes to `ST_HIGH` and force-low goes to `ST_LOW` from either state. Hold keeps the current state.

Top module: `timer_ffout_ctrl`

## Requirements
- R1: During and right after reset, `ff_o` is 0 and `irq_o` is 0.
- R2: A comparator registers a match only on a cycle where `count_i` equals its reference and did not equal it on the previous cycle. The first cycle after reset counts as having no previous equality. A counter that stays equal produces no further match.
- R3: `irq_o` is high for the cycle after any clock edge at which either comparator registered a match, and low otherwise.
- R4: Each source flips `ff_o` at the next edge only when its own enable is 1. The four source/enable pairs are: `cmp0` match with `en_match0_i`, `cmp1` match with `en_match1_i`, `cap0_evt_i` with `en_cap0_i`, and `cap1_evt_i` with `en_cap1_i`.
- R5: When several enabled sources fire at the same edge, `ff_o` flips once per firing source. An even count leaves it unchanged and an odd count flips it.
- R6: With `cmd_wr_i` high, `cmd_i` = 2'b00 inverts `ff_o`, 2'b01 sets it to 1, and 2'b10 clears it to 0, each at the next edge.
- R7: A valid command (2'b00, 2'b01 or 2'b10) with `cmd_wr_i` high overrides every hardware flip at the same edge.
- R8: A write of `cmd_i` = 2'b11 has no effect. Hardware flips at that edge act as if no write had occurred.
- R9: A disabled source leaves `ff_o` unchanged, but a comparator match still raises `irq_o` whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 16 | Up-counter value |
| cmp0_val_i | input | 16 | Reference value for comparator 0 |
| cmp1_val_i | input | 16 | Reference value for comparator 1 |
| cap0_evt_i | input | 1 | Capture-latch strobe 0 |
| cap1_evt_i | input | 1 | Capture-latch strobe 1 |
| en_match0_i | input | 1 | Flip enable for comparator 0 match |
| en_match1_i | input | 1 | Flip enable for comparator 1 match |
| en_cap0_i | input | 1 | Flip enable for capture strobe 0 |
| en_cap1_i | input | 1 | Flip enable for capture strobe 1 |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command: 00 invert, 01 set, 10 clear, 11 no effect |
| ff_o | output | 1 | Output flip-flop state |
| irq_o | output | 1 | Timer interrupt pulse |

## Verification
The directed tests hold the counter on a reference for two cycles. This shows that a match is an edge rather than a level, for both the interrupt and the flip. Single strobes are driven with their enable on and then off, which separates the enable gating from the interrupt path. Pairs and triples of simultaneous events tell a parity merge apart from an OR merge. Commands are issued together with hardware events to show that a valid command overrides them, while code 11 lets the hardware flip through.

// File: rtl/tfo_pkg.sv
package tfo_pkg;

    localparam int unsigned TFO_CNT_W   = 16;
    localparam int unsigned TFO_NUM_CMP = 2;
    localparam int unsigned TFO_NUM_CAP = 2;
    localparam int unsigned TFO_NUM_SRC = TFO_NUM_CMP + TFO_NUM_CAP;

    typedef enum logic [1:0] {
        CMD_INVERT = 2'b00,
        CMD_SET    = 2'b01,
        CMD_CLEAR  = 2'b10,
        CMD_NOP    = 2'b11
    } ff_cmd_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } ff_state_e;

endpackage

// File: rtl/tfo_match_edge.sv
module tfo_match_edge #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] ref_i,
    output logic             hit_o
);

    logic eq_now;
    logic eq_q;

    always_comb begin
        eq_now = (count_i == ref_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq_now;
        end
    end

    always_comb begin
        hit_o = eq_now && !eq_q;
    end

    // R2: a lasting equality never yields two consecutive hits
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);

    // R2: an equality that holds over two edges gives no hit on the second
    assert_no_rehit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == ref_i) |=> ((count_i == ref_i) |-> !hit_o));

endmodule

// File: rtl/tfo_toggle_merge.sv
module tfo_toggle_merge #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] en_i,
    output logic             flip_o
);

    logic [N_SRC-1:0] gated;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        always_comb begin
            gated[g] = evt_i[g] & en_i[g];
        end
    end

    always_comb begin
        flip_o = ^gated;
    end

endmodule

// File: rtl/tfo_ff_core.sv
module tfo_ff_core
    import tfo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flip_i,
    input  logic       cmd_wr_i,
    input  logic [1:0] cmd_i,
    output logic       ff_o
);

    ff_state_e state_q;
    ff_state_e state_d;
    ff_cmd_e   cmd;
    logic      cmd_valid;

    always_comb begin
        cmd       = ff_cmd_e'(cmd_i);
        cmd_valid = cmd_wr_i && (cmd != CMD_NOP);
    end

    // next-state selection: command first, then hardware flip, else hold
    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (cmd)
                CMD_INVERT: state_d = (state_q == ST_LOW) ? ST_HIGH : ST_LOW;
                CMD_SET:    state_d = ST_HIGH;
                CMD_CLEAR:  state_d = ST_LOW;
                default:    state_d = state_q;
            endcase
        end else if (flip_i) begin
            unique case (state_q)
                ST_LOW:  state_d = ST_HIGH;
                ST_HIGH: state_d = ST_LOW;
                default: state_d = ST_LOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        ff_o = (state_q == ST_HIGH);
    end

    assert_set_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i == 2'b01) |=> ff_o);

    assert_clear_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i == 2'b10) |=> !ff_o);

    // R7: invert command flips exactly once whatever the hardware does
    assert_invert_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i == 2'b00) |=> (ff_o != $past(ff_o)));

    assert_hw_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cmd_wr_i || cmd_i == 2'b11) && flip_i) |=> (ff_o != $past(ff_o)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cmd_wr_i || cmd_i == 2'b11) && !flip_i) |=> $stable(ff_o));

endmodule

// File: rtl/timer_ffout_ctrl.sv
module timer_ffout_ctrl
    import tfo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TFO_CNT_W-1:0] count_i,
    input  logic [TFO_CNT_W-1:0] cmp0_val_i,
    input  logic [TFO_CNT_W-1:0] cmp1_val_i,
    input  logic                 cap0_evt_i,
    input  logic                 cap1_evt_i,
    input  logic                 en_match0_i,
    input  logic                 en_match1_i,
    input  logic                 en_cap0_i,
    input  logic                 en_cap1_i,
    input  logic                 cmd_wr_i,
    input  logic [1:0]           cmd_i,
    output logic                 ff_o,
    output logic                 irq_o
);

    logic [TFO_CNT_W-1:0]   ref_val [TFO_NUM_CMP];
    logic [TFO_NUM_CMP-1:0] hit;
    logic [TFO_NUM_SRC-1:0] src_evt;
    logic [TFO_NUM_SRC-1:0] src_en;
    logic                   flip;
    logic                   irq_q;

    always_comb begin
        ref_val[0] = cmp0_val_i;
        ref_val[1] = cmp1_val_i;
    end

    for (genvar c = 0; c < TFO_NUM_CMP; c++) begin : g_cmp
        tfo_match_edge #(
            .CNT_W (TFO_CNT_W)
        ) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_i (count_i),
            .ref_i   (ref_val[c]),
            .hit_o   (hit[c])
        );
    end

    always_comb begin
        src_evt = {cap1_evt_i, cap0_evt_i, hit};
        src_en  = {en_cap1_i, en_cap0_i, en_match1_i, en_match0_i};
    end

    tfo_toggle_merge #(
        .N_SRC (TFO_NUM_SRC)
    ) u_merge (
        .evt_i  (src_evt),
        .en_i   (src_en),
        .flip_o (flip)
    );

    tfo_ff_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .flip_i   (flip),
        .cmd_wr_i (cmd_wr_i),
        .cmd_i    (cmd_i),
        .ff_o     (ff_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |hit;
        end
    end

    always_comb begin
        irq_o = irq_q;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (!ff_o && !irq_o));

    assert_irq_follows_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> irq_o);

    assert_irq_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit)) |=> !irq_o);

endmodule

// File: tb/timer_ffout_ctrl_tb.sv
module timer_ffout_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] REF0 = 16'd100;
    localparam logic [15:0] REF1 = 16'd200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = 16'd0;
    logic [15:0] cmp0_val_i = REF0;
    logic [15:0] cmp1_val_i = REF1;
    logic        cap0_evt_i = 1'b0;
    logic        cap1_evt_i = 1'b0;
    logic        en_match0_i = 1'b0;
    logic        en_match1_i = 1'b0;
    logic        en_cap0_i = 1'b0;
    logic        en_cap1_i = 1'b0;
    logic        cmd_wr_i = 1'b0;
    logic [1:0]  cmd_i = 2'b11;
    logic        ff_o;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_ffout_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i),
        .cmp0_val_i(cmp0_val_i), .cmp1_val_i(cmp1_val_i),
        .cap0_evt_i(cap0_evt_i), .cap1_evt_i(cap1_evt_i),
        .en_match0_i(en_match0_i), .en_match1_i(en_match1_i),
        .en_cap0_i(en_cap0_i), .en_cap1_i(en_cap1_i),
        .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
        .ff_o(ff_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // advance one edge, then sample away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_en(input logic m0, input logic m1, input logic c0, input logic c1);
        en_match0_i = m0; en_match1_i = m1; en_cap0_i = c0; en_cap1_i = c1;
    endtask

    task automatic issue_cmd(input logic [1:0] c);
        cmd_wr_i = 1'b1; cmd_i = c;
        tick();
        cmd_wr_i = 1'b0; cmd_i = 2'b11;
    endtask

    task automatic t_reset();
        check("R1", "ff in reset", ff_o, 1'b0);
        check("R1", "irq in reset", irq_o, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1", "ff after reset", ff_o, 1'b0);
        check("R1", "irq after reset", irq_o, 1'b0);
    endtask

    task automatic t_match();
        set_en(1'b1, 1'b0, 1'b0, 1'b0);
        count_i = REF0;
        tick();
        check("R4", "match0 flips ff", ff_o, 1'b1);
        check("R3", "irq on match0", irq_o, 1'b1);
        tick();
        check("R2", "held equality no reflip", ff_o, 1'b1);
        check("R2", "held equality no irq", irq_o, 1'b0);
        count_i = 16'd0;
        set_en(1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        check("R3", "irq low without match", irq_o, 1'b0);
    endtask

    task automatic t_disabled_match();
        count_i = REF1;
        tick();
        check("R9", "disabled match1 keeps ff", ff_o, 1'b1);
        check("R9", "disabled match1 still irq", irq_o, 1'b1);
        count_i = 16'd0;
        tick();
        check("R3", "irq drops", irq_o, 1'b0);
    endtask

    task automatic t_capture();
        set_en(1'b0, 1'b0, 1'b1, 1'b0);
        cap0_evt_i = 1'b1; tick(); cap0_evt_i = 1'b0;
        check("R4", "cap0 flips ff", ff_o, 1'b0);
        cap1_evt_i = 1'b1; tick(); cap1_evt_i = 1'b0;
        check("R9", "disabled cap1 keeps ff", ff_o, 1'b0);
        set_en(1'b0, 1'b0, 1'b0, 1'b1);
        cap1_evt_i = 1'b1; tick(); cap1_evt_i = 1'b0;
        check("R4", "cap1 flips ff", ff_o, 1'b1);
        check("R9", "capture gives no irq", irq_o, 1'b0);
    endtask

    task automatic t_parity();
        set_en(1'b0, 1'b0, 1'b1, 1'b1);
        cap0_evt_i = 1'b1; cap1_evt_i = 1'b1;
        tick();
        check("R5", "two events cancel", ff_o, 1'b1);
        set_en(1'b1, 1'b0, 1'b1, 1'b1);
        count_i = REF0;
        tick();
        cap0_evt_i = 1'b0; cap1_evt_i = 1'b0;
        check("R5", "three events flip once", ff_o, 1'b0);
        check("R3", "irq with triple", irq_o, 1'b1);
        count_i = 16'd0;
        set_en(1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        check("R5", "quiet after triple", ff_o, 1'b0);
    endtask

    task automatic t_cmd();
        issue_cmd(2'b01);
        check("R6", "set cmd", ff_o, 1'b1);
        issue_cmd(2'b01);
        check("R6", "set cmd again", ff_o, 1'b1);
        issue_cmd(2'b10);
        check("R6", "clear cmd", ff_o, 1'b0);
        issue_cmd(2'b00);
        check("R6", "invert to 1", ff_o, 1'b1);
        issue_cmd(2'b00);
        check("R6", "invert to 0", ff_o, 1'b0);
        issue_cmd(2'b11);
        check("R8", "cmd 11 ignored", ff_o, 1'b0);
    endtask

    task automatic t_override();
        issue_cmd(2'b01);
        set_en(1'b0, 1'b0, 1'b1, 1'b0);
        cap0_evt_i = 1'b1;
        issue_cmd(2'b01);
        check("R7", "set beats flip", ff_o, 1'b1);
        issue_cmd(2'b10);
        check("R7", "clear wins with flip", ff_o, 1'b0);
        issue_cmd(2'b00);
        check("R7", "invert not doubled", ff_o, 1'b1);
        cap0_evt_i = 1'b0;
    endtask

    task automatic t_nop_with_hw();
        cap0_evt_i = 1'b1;
        issue_cmd(2'b11);
        cap0_evt_i = 1'b0;
        check("R8", "cmd 11 lets flip through", ff_o, 1'b0);
        set_en(1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        check("R8", "hold afterwards", ff_o, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 1);
        t_reset();
        t_match();
        t_disabled_match();
        t_capture();
        t_parity();
        t_cmd();
        t_override();
        t_nop_with_hw();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule